// File: doc/BRIEF.md
# Dual-Channel Countdown Watchdog

This block holds two independent countdown watchdogs that share one 1 Hz tick input. Software loads a start count into a channel and enables it. Each qualifying tick then lowers the count by one. When a channel's count runs out, the block sets a timeout flag for that channel. The flag stays set until software clears it by writing a one to it. Writing a count register again reloads the channel, and this reload is the way to kick the watchdog.

Channel A always counts in seconds and takes a 7-bit start value. Channel B takes a start value from 0 to 256 and counts in either seconds or minutes. A unit-select bit chooses between the two. In minute mode, a divide-by-60 prescaler on the tick input produces one step per minute. The register port uses a single-cycle write strobe and a combinational read path, both driven by a 2-bit register address.

Top module: `dual_wdt`

## Requirements
- R1: After reset, every register reads zero: both counts, the control bits and both status bits. Both expired outputs are low.
- R2: A write to address 0 loads channel A with the low 7 bits of wdata. The upper bits are ignored. While channel A is enabled, each tick lowers its count by one. Reading address 0 returns the count in bits 6:0.
- R3: A write to address 1 loads channel B. A value above 256 is clamped to 256. Reading address 1 returns the 9-bit count in bits 8:0.
- R4: The control register is at address 2. Bit 0 enables channel A, bit 1 enables channel B, and bit 2 selects minutes for channel B (0 selects seconds). When a channel's enable bit is 0, its count stays frozen.
- R5: When an enabled channel's count steps to zero, that channel's status bit is set. The count then stays at zero and never wraps.
- R6: If an enabled channel holds zero, its next step sets its status bit. This covers a load of 0 and also the case where the status was cleared while the count sat at zero.
- R7: The status register is at address 3, with bit 0 for channel A and bit 1 for channel B. A status bit stays set until a 1 is written to it. Writing 0 to a status bit leaves it unchanged. The expired_a and expired_b outputs follow the status bits.
- R8: If a write-one-to-clear and a new timeout fall in the same cycle, the status bit ends up set.
- R9: In minute mode, channel B steps once for every 60 ticks. In seconds mode, it steps on every tick.
- R10: A count write that coincides with a step takes priority over the step. A write to channel B's count also restarts the minute prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr (combinational) |
| expired_a | output | 1 | Channel A status bit |
| expired_b | output | 1 | Channel B status bit |

## Verification
The embedded assertions check the following on every cycle: the count never wraps below zero, a frozen channel holds its count, a step without a load lowers the count by exactly one, a timeout event always leaves the status set, status bits only fall when cleared, and the prescaler stays in range. Other behaviour depends on how stimulus is arranged over time, so only the directed scenarios can show it. This includes the exact tick on which a count expires, how masked and clamped load values read back, the effect of a kick in the middle of a count, the 60-tick minute boundary with its prescaler restart, and a clear that collides with a timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_CNT_A = 2'd0,
    REG_CNT_B = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STS   = 2'd3
  } wdt_reg_e;

  localparam int CTRL_EN_A  = 0;
  localparam int CTRL_EN_B  = 1;
  localparam int CTRL_MIN_B = 2;
  localparam int CTRL_W     = 3;

  localparam int STS_A = 0;
  localparam int STS_B = 1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic advance,
  output logic wrap
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;

  function automatic logic [PW-1:0] next_pre(input logic [PW-1:0] cur);
    if (cur == PW'(DIV - 1)) return '0;
    return cur + PW'(1);
  endfunction

  assign wrap = advance && !clr && (pre == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       pre <= '0;
    else if (clr)     pre <= '0;
    else if (advance) pre <= next_pre(pre);
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PW'(DIV - 1)); // R9
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pre == '0); // R10
endmodule

// File: rtl/wdt_chan.sv
module wdt_chan #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic         step,
  input  logic         clr_sts,
  output logic [W-1:0] cnt,
  output logic         sts,
  output logic         expire
);
  logic live_step;

  function automatic logic [W-1:0] dec_sat(input logic [W-1:0] v);
    return (v == '0) ? '0 : v - W'(1);
  endfunction

  assign live_step = en && step && !load;
  assign expire    = live_step && (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (live_step) cnt <= dec_sat(cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sts <= 1'b0;
    else if (expire)  sts <= 1'b1;
    else if (clr_sts) sts <= 1'b0;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !load && cnt != '0) |=> cnt == $past(cnt) - W'(1)); // R2
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sts); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr_sts) |=> sts); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val)); // R10
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt #(
  parameter int DW      = 16,
  parameter int A_W     = 7,
  parameter int B_W     = 9,
  parameter int B_MAX   = 256,
  parameter int MIN_DIV = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          expired_a,
  output logic          expired_b
);
  import wdt_pkg::*;

  logic [CTRL_W-1:0] ctrl;
  logic              load_a, load_b, clr_a, clr_b, sts_wr;
  logic              pre_wrap, step_b;
  logic [A_W-1:0]    cnt_a;
  logic [B_W-1:0]    cnt_b;
  logic              sts_a, sts_b, expire_a, expire_b;

  function automatic logic [B_W-1:0] clamp_b(input logic [DW-1:0] v);
    if (v > DW'(B_MAX)) return B_W'(B_MAX);
    return v[B_W-1:0];
  endfunction

  assign load_a = wr_en && (addr == REG_CNT_A);
  assign load_b = wr_en && (addr == REG_CNT_B);
  assign sts_wr = wr_en && (addr == REG_STS);
  assign clr_a  = sts_wr && wdata[STS_A];
  assign clr_b  = sts_wr && wdata[STS_B];

  always_ff @(posedge clk) begin
    if (!rst_n)                         ctrl <= '0;
    else if (wr_en && addr == REG_CTRL) ctrl <= wdata[CTRL_W-1:0];
  end

  wdt_prescaler #(.DIV(MIN_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(load_b),
    .advance(tick_1hz && ctrl[CTRL_EN_B] && ctrl[CTRL_MIN_B]),
    .wrap(pre_wrap)
  );

  assign step_b = ctrl[CTRL_MIN_B] ? pre_wrap : tick_1hz;

  wdt_chan #(.W(A_W)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .load(load_a), .load_val(wdata[A_W-1:0]),
    .en(ctrl[CTRL_EN_A]), .step(tick_1hz), .clr_sts(clr_a),
    .cnt(cnt_a), .sts(sts_a), .expire(expire_a)
  );

  wdt_chan #(.W(B_W)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .load(load_b), .load_val(clamp_b(wdata)),
    .en(ctrl[CTRL_EN_B]), .step(step_b), .clr_sts(clr_b),
    .cnt(cnt_b), .sts(sts_b), .expire(expire_b)
  );

  always_comb begin
    unique case (addr)
      REG_CNT_A: rdata = DW'(cnt_a);
      REG_CNT_B: rdata = DW'(cnt_b);
      REG_CTRL:  rdata = DW'(ctrl);
      default:   rdata = DW'({sts_b, sts_a});
    endcase
  end

  assign expired_a = sts_a;
  assign expired_b = sts_b;

  AST_B_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_b <= B_W'(B_MAX)); // R3
  AST_MIN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTRL_MIN_B] && !pre_wrap && !load_b) |=> $stable(cnt_b)); // R9
  AST_EXPIRE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(expire_a && !ctrl[CTRL_EN_A]) && !(expire_b && !ctrl[CTRL_EN_B])); // R4
endmodule

// File: tb/sim_dual_wdt.sv
module sim_dual_wdt;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1hz = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          expired_a, expired_b;
  int            checks = 0;
  int            errors = 0;

  always #2 clk = ~clk;

  dual_wdt u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .expired_a(expired_a), .expired_b(expired_b)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); addr = a; wdata = DW'(d); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [1:0] a, input int d);
    @(negedge clk); addr = a; wdata = DW'(d); wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 expired_a", int'(expired_a), 0);
    chk("R1 expired_b", int'(expired_b), 0);
  endtask

  task automatic t_a_count;
    int v;
    wr(2'd2, 1); wr(2'd0, 5);
    tk(4); rd(2'd0, v); chk("R2 count after 4", v, 1);
    rd(2'd3, v); chk("R5 no early status", v, 0);
    tk(1); rd(2'd0, v); chk("R5 reached zero", v, 0);
    chk("R5 expired_a", int'(expired_a), 1);
    tk(3); rd(2'd0, v); chk("R5 no wrap", v, 0);
    wr(2'd3, 1); wr(2'd2, 0);
    rd(2'd3, v); chk("R7 cleared", v, 0);
  endtask

  task automatic t_a_mask;
    int v;
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R2 upper bits ignored", v, 127);
  endtask

  task automatic t_freeze;
    int v;
    wr(2'd2, 1); wr(2'd0, 10); tk(2);
    rd(2'd0, v); chk("R4 counting", v, 8);
    wr(2'd2, 0); tk(3);
    rd(2'd0, v); chk("R4 frozen", v, 8);
    rd(2'd2, v); chk("R4 ctrl readback", v, 0);
  endtask

  task automatic t_zero;
    int v;
    wr(2'd2, 1); wr(2'd0, 0);
    rd(2'd3, v); chk("R6 no status before step", v, 0);
    tk(1); rd(2'd3, v); chk("R6 load zero expires", v, 1);
    wr(2'd3, 1); rd(2'd3, v); chk("R7 clear", v, 0);
    tk(1); rd(2'd3, v); chk("R6 re-asserts at zero", v, 1);
  endtask

  task automatic t_w1c;
    int v;
    wr(2'd3, 2); rd(2'd3, v); chk("R7 other bit write keeps A", v, 1);
    wr(2'd3, 0); rd(2'd3, v); chk("R7 write zero keeps", v, 1);
    wr(2'd3, 1); rd(2'd3, v); chk("R7 write one clears", v, 0);
    wr(2'd2, 0);
  endtask

  task automatic t_collide;
    int v;
    wr(2'd2, 1); wr(2'd0, 0); tk(1);
    wr_tick(2'd3, 1); rd(2'd3, v); chk("R8 set wins over clear", v, 1);
    wr(2'd3, 1); wr(2'd2, 0);
  endtask

  task automatic t_kick;
    int v;
    wr(2'd2, 1); wr(2'd0, 3); tk(2);
    rd(2'd0, v); chk("R10 before kick", v, 1);
    wr(2'd0, 3); rd(2'd0, v); chk("R10 kick reloads", v, 3);
    tk(2); rd(2'd3, v); chk("R10 no timeout after kick", v, 0);
    wr_tick(2'd0, 4); rd(2'd0, v); chk("R10 load beats step", v, 4);
    wr(2'd2, 0);
  endtask

  task automatic t_b_sec;
    int v;
    wr(2'd2, 2); wr(2'd1, 3); tk(3);
    rd(2'd1, v); chk("R9 seconds mode", v, 0);
    chk("R5 expired_b", int'(expired_b), 1);
    rd(2'd3, v); chk("R7 status bit 1", v, 2);
    wr(2'd3, 2);
    wr(2'd1, 300); rd(2'd1, v); chk("R3 clamp", v, 256);
    wr(2'd1, 256); rd(2'd1, v); chk("R3 max value", v, 256);
    wr(2'd1, 255); rd(2'd1, v); chk("R3 in range", v, 255);
  endtask

  task automatic t_b_min;
    int v;
    wr(2'd2, 6); wr(2'd1, 2);
    tk(59); rd(2'd1, v); chk("R9 before minute", v, 2);
    tk(1);  rd(2'd1, v); chk("R9 first minute", v, 1);
    tk(60); rd(2'd1, v); chk("R9 second minute", v, 0);
    chk("R9 minute timeout", int'(expired_b), 1);
    wr(2'd3, 2);
    wr(2'd1, 2); tk(30); wr(2'd1, 2);
    tk(59); rd(2'd1, v); chk("R10 prescaler restarted", v, 2);
    tk(1);  rd(2'd1, v); chk("R10 full minute after reload", v, 1);
    wr(2'd2, 0);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog got 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_a_count;
    t_a_mask;
    t_freeze;
    t_zero;
    t_w1c;
    t_collide;
    t_kick;
    t_b_sec;
    t_b_min;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule